// File: doc/BRIEF.md
# Asymmetric-Width Dual-Port Memory

This block is a 4096-bit synchronous memory with two read/write ports. Each port has its own clock, enable, write enable, synchronous output reset, address, write data and registered read data. The two ports need not share a clock. Each port's data width is fixed when the block is elaborated. It can be 1, 2, 4, 8 or 16 bits, and the two ports may use different widths.

Both ports address the same bit array, each through its own aspect ratio. A narrow word on one port therefore aliases a fixed slice of a wide word on the other port. A producer can write 4-bit nibbles on one side and a consumer can read 16-bit words on the other, and the width conversion needs no extra logic.

If both ports write overlapping bits in the same instant, the overlapping bits become undefined. If one port reads bits while the other port writes them, the read returns either the old or the new contents.

Top module: `asym_dpram`

## Requirements
- R1: A port of width W (1, 2, 4, 8 or 16) has 4096/W words and an address of 12 − log2(W) bits. The last address reaches the top bits of the array.
- R2: Word n of a W-bit port occupies array bits W·n up to W·n+W−1, with its bit 0 at the lowest of those bits. Data written on one port is seen at the aliased position by the other port.
- R3: With enable high, reset low and write enable low, the port's output holds the addressed word one clock edge later.
- R4: With enable, write enable high and reset low, the addressed word is written and the output shows the written data after the same edge (write-first).
- R5: With enable low, write enable is ignored and the output keeps its previous value. The array word is unchanged, which a later read shows.
- R6: With enable and reset high, the output is loaded with that port's init parameter after the edge, whatever the read address holds.
- R7: With enable, reset and write enable all high, the array word is still written, and a later read returns it.
- R8: Every array bit is zero at power-up, so a read before any write returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clkA | input | 1 | Port A clock |
| enA | input | 1 | Port A enable |
| weA | input | 1 | Port A write enable |
| rstA | input | 1 | Port A synchronous output reset |
| addrA | input | ADDR_A | Port A word address |
| dinA | input | WIDTH_A | Port A write data |
| doutA | output | WIDTH_A | Port A registered read data |
| clkB | input | 1 | Port B clock |
| enB | input | 1 | Port B enable |
| weB | input | 1 | Port B write enable |
| rstB | input | 1 | Port B synchronous output reset |
| addrB | input | ADDR_B | Port B word address |
| dinB | input | WIDTH_B | Port B write data |
| doutB | output | WIDTH_B | Port B registered read data |

## Verification
The per-port properties assume that the other port does not write the bits under check during the window being checked. They also stay disarmed until the port has seen its first enabled reset, because before that the output register holds no defined value. The directed stimulus uses one port at a time. The two clocks run at a fixed phase offset, so no cross-port write ever overlaps a read of the same bits. Each scenario starts with an enabled reset on both ports before any property is relied on.

// File: rtl/asym_dpram_pkg.sv
package asym_dpram_pkg;

  localparam int STORE_BITS      = 4096;
  localparam int STORE_ADDR_BITS = $clog2(STORE_BITS);

  // Strobes handed from a port's control decode to its datapath slice
  typedef struct packed {
    logic wrStb;    // commit write data to the array
    logic loadStb;  // output register takes read / write-first data
    logic rstStb;   // output register takes the init value
  } portStrobe_t;

  function automatic int portAddrBits(input int width);
    return STORE_ADDR_BITS - $clog2(width);
  endfunction

endpackage

// File: rtl/asym_dpram_ctrl.sv
module asym_dpram_ctrl
  import asym_dpram_pkg::*;
(
  input  logic        en,
  input  logic        we,
  input  logic        rst,
  output portStrobe_t strb
);

  // Everything is qualified by enable; reset beats the read path only
  always_comb begin
    strb.wrStb   = en & we;
    strb.rstStb  = en & rst;
    strb.loadStb = en & ~rst;
  end

endmodule

// File: rtl/asym_dpram_bank.sv
module asym_dpram_bank
  import asym_dpram_pkg::*;
#(
  parameter int             W    = 4,
  parameter logic [W-1:0]   INIT = '0,
  localparam int            SHIFT = $clog2(W),
  localparam int            AW    = STORE_ADDR_BITS - SHIFT
) (
  input  logic                  clk,
  input  portStrobe_t           strb,
  input  logic [AW-1:0]         addr,
  input  logic [W-1:0]          din,
  input  logic [STORE_BITS-1:0] otherBank,
  output logic [STORE_BITS-1:0] ownBank,
  output logic [W-1:0]          dout
);

  // This port's share of the array; stored word = ownBank ^ otherBank
  logic [STORE_BITS-1:0]      store = '0;
  logic [STORE_ADDR_BITS-1:0] bitBase;
  logic [W-1:0]               curWord;

  assign ownBank = store;
  assign bitBase = STORE_ADDR_BITS'(addr) << SHIFT;
  assign curWord = store[bitBase +: W] ^ otherBank[bitBase +: W];

  always_ff @(posedge clk) begin
    if (strb.wrStb)
      store[bitBase +: W] <= din ^ otherBank[bitBase +: W];
  end

  always_ff @(posedge clk) begin
    if (strb.rstStb)
      dout <= INIT;
    else if (strb.loadStb)
      dout <= strb.wrStb ? din : curWord;
  end

endmodule

// File: rtl/asym_dpram.sv
module asym_dpram
  import asym_dpram_pkg::*;
#(
  parameter int                 WIDTH_A = 4,
  parameter int                 WIDTH_B = 16,
  parameter logic [WIDTH_A-1:0] INIT_A  = '0,
  parameter logic [WIDTH_B-1:0] INIT_B  = '0,
  localparam int                ADDR_A  = portAddrBits(WIDTH_A),
  localparam int                ADDR_B  = portAddrBits(WIDTH_B)
) (
  input  logic               clkA,
  input  logic               enA,
  input  logic               weA,
  input  logic               rstA,
  input  logic [ADDR_A-1:0]  addrA,
  input  logic [WIDTH_A-1:0] dinA,
  output logic [WIDTH_A-1:0] doutA,
  input  logic               clkB,
  input  logic               enB,
  input  logic               weB,
  input  logic               rstB,
  input  logic [ADDR_B-1:0]  addrB,
  input  logic [WIDTH_B-1:0] dinB,
  output logic [WIDTH_B-1:0] doutB
);

  portStrobe_t           strbA, strbB;
  logic [STORE_BITS-1:0] bankA, bankB;

  asym_dpram_ctrl u_ctrlA (.en(enA), .we(weA), .rst(rstA), .strb(strbA));
  asym_dpram_ctrl u_ctrlB (.en(enB), .we(weB), .rst(rstB), .strb(strbB));

  asym_dpram_bank #(.W(WIDTH_A), .INIT(INIT_A)) u_bankA (
    .clk(clkA), .strb(strbA), .addr(addrA), .din(dinA),
    .otherBank(bankB), .ownBank(bankA), .dout(doutA)
  );

  asym_dpram_bank #(.W(WIDTH_B), .INIT(INIT_B)) u_bankB (
    .clk(clkB), .strb(strbB), .addr(addrB), .din(dinB),
    .otherBank(bankA), .ownBank(bankB), .dout(doutB)
  );

endmodule

// File: rtl/asym_dpram_checker.sv
module asym_dpram_checker
  import asym_dpram_pkg::*;
#(
  parameter int                 WIDTH_A = 4,
  parameter int                 WIDTH_B = 16,
  parameter logic [WIDTH_A-1:0] INIT_A  = '0,
  parameter logic [WIDTH_B-1:0] INIT_B  = '0,
  localparam int                ADDR_A  = portAddrBits(WIDTH_A),
  localparam int                ADDR_B  = portAddrBits(WIDTH_B)
) (
  input logic               clkA,
  input logic               enA,
  input logic               weA,
  input logic               rstA,
  input logic [ADDR_A-1:0]  addrA,
  input logic [WIDTH_A-1:0] dinA,
  input logic [WIDTH_A-1:0] doutA,
  input logic               clkB,
  input logic               enB,
  input logic               weB,
  input logic               rstB,
  input logic [ADDR_B-1:0]  addrB,
  input logic [WIDTH_B-1:0] dinB,
  input logic [WIDTH_B-1:0] doutB
);

  // A port's properties arm after its first enabled reset
  logic armA = 1'b0;
  logic armB = 1'b0;

  always_ff @(posedge clkA) if (enA && rstA) armA <= 1'b1;
  always_ff @(posedge clkB) if (enB && rstB) armB <= 1'b1;

  p_a_rst_init_r6: assert property (@(posedge clkA) disable iff (!armA)
    (enA && rstA) |=> (doutA == INIT_A));
  p_b_rst_init_r6: assert property (@(posedge clkB) disable iff (!armB)
    (enB && rstB) |=> (doutB == INIT_B));

  p_a_hold_r5: assert property (@(posedge clkA) disable iff (!armA)
    !enA |=> $stable(doutA));
  p_b_hold_r5: assert property (@(posedge clkB) disable iff (!armB)
    !enB |=> $stable(doutB));

  p_a_write_first_r4: assert property (@(posedge clkA) disable iff (!armA)
    (enA && weA && !rstA) |=> (doutA == $past(dinA)));
  p_b_write_first_r4: assert property (@(posedge clkB) disable iff (!armB)
    (enB && weB && !rstB) |=> (doutB == $past(dinB)));

  p_a_read_back_r3: assert property (@(posedge clkA) disable iff (!armA)
    (enA && weA && !rstA) ##1 (enA && !weA && !rstA && addrA == $past(addrA))
      |=> (doutA == $past(dinA, 2)));
  p_b_read_back_r3: assert property (@(posedge clkB) disable iff (!armB)
    (enB && weB && !rstB) ##1 (enB && !weB && !rstB && addrB == $past(addrB))
      |=> (doutB == $past(dinB, 2)));

endmodule

bind asym_dpram asym_dpram_checker #(
  .WIDTH_A(WIDTH_A), .WIDTH_B(WIDTH_B), .INIT_A(INIT_A), .INIT_B(INIT_B)
) u_checker (.*);

// File: tb/asym_dpram_bench.sv
module asym_dpram_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WA  = 4;
  localparam int WB  = 16;
  localparam int AWA = 10;
  localparam int AWB = 8;
  localparam logic [WA-1:0] IA = 4'hA;
  localparam logic [WB-1:0] IB = 16'h5A5A;

  logic clkA = 1'b0, clkB = 1'b0;
  logic enA = 0, weA = 0, rstA = 0, enB = 0, weB = 0, rstB = 0;
  logic [AWA-1:0] addrA = '0;
  logic [AWB-1:0] addrB = '0;
  logic [WA-1:0]  dinA = '0, doutA, prevA = '0;
  logic [WB-1:0]  dinB = '0, doutB, prevB = '0;

  logic [4095:0] model = '0;  // requirement-level image of the array
  int checks = 0, errors = 0;
  bit done = 0;

  asym_dpram #(.WIDTH_A(WA), .WIDTH_B(WB), .INIT_A(IA), .INIT_B(IB)) u_asym_dpram (
    .clkA(clkA), .enA(enA), .weA(weA), .rstA(rstA), .addrA(addrA), .dinA(dinA), .doutA(doutA),
    .clkB(clkB), .enB(enB), .weB(weB), .rstB(rstB), .addrB(addrB), .dinB(dinB), .doutB(doutB)
  );

  always #(CLK_PERIOD/2) clkA = ~clkA;
  initial begin
    #(CLK_PERIOD/4);
    forever #(CLK_PERIOD/2) clkB = ~clkB;
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // One port-A cycle; expected output derived from the requirements
  task automatic portA(input logic en, we, rst, input int addr, input logic [WA-1:0] din,
                       input string req);
    logic [WA-1:0] exp;
    if (!en)       exp = prevA;
    else if (rst)  exp = IA;
    else if (we)   exp = din;
    else           exp = model[addr*WA +: WA];
    if (en && we) model[addr*WA +: WA] = din;
    enA = en; weA = we; rstA = rst; addrA = AWA'(addr); dinA = din;
    @(posedge clkA); #1;
    check(req, 16'(doutA), 16'(exp));
    prevA = exp;
    enA = 0; weA = 0; rstA = 0;
  endtask

  task automatic portB(input logic en, we, rst, input int addr, input logic [WB-1:0] din,
                       input string req);
    logic [WB-1:0] exp;
    if (!en)       exp = prevB;
    else if (rst)  exp = IB;
    else if (we)   exp = din;
    else           exp = model[addr*WB +: WB];
    if (en && we) model[addr*WB +: WB] = din;
    enB = en; weB = we; rstB = rst; addrB = AWB'(addr); dinB = din;
    @(posedge clkB); #1;
    check(req, doutB, exp);
    prevB = exp;
    enB = 0; weB = 0; rstB = 0;
  endtask

  task automatic testResetState();
    portA(1, 0, 1, 0, '0, "R6 port A reset to init");
    portB(1, 0, 1, 0, '0, "R6 port B reset to init");
  endtask

  task automatic testPowerUpZero();
    portA(1, 0, 0, 5, '0, "R8 port A unwritten word");
    portB(1, 0, 0, 200, '0, "R8 port B unwritten word");
  endtask

  task automatic testNarrowToWide();
    for (int i = 0; i < 4; i++) portA(1, 1, 0, i, 4'(i + 3), "R4 port A write-first");
    portB(1, 0, 0, 0, '0, "R2 nibbles gathered into word 0");
    check("R2 explicit lane order", doutB, 16'h6543);
  endtask

  task automatic testWideToNarrow();
    portB(1, 1, 0, 1, 16'hBEEF, "R4 port B write-first");
    for (int i = 4; i < 8; i++) portA(1, 0, 0, i, '0, "R2 R3 port A reads lanes of word 1");
    portB(1, 1, 0, 255, 16'h1234, "R4 port B top word");
    portA(1, 0, 0, 1023, '0, "R1 last port A address");
    check("R1 last nibble value", 16'(doutA), 16'h0001);
    portA(1, 0, 0, 1020, '0, "R1 port A address 1020");
  endtask

  task automatic testEnableLow();
    portA(1, 0, 0, 0, '0, "R3 read before disabled write");
    portA(0, 1, 0, 0, 4'hF, "R5 port A holds output");
    portA(1, 0, 0, 0, '0, "R5 disabled write left word");
    portB(0, 1, 1, 0, 16'hFFFF, "R5 port B holds output");
    portB(1, 0, 0, 0, '0, "R5 port B word unchanged");
  endtask

  task automatic testResetPriority();
    portA(1, 0, 1, 1, '0, "R6 reset beats read");
    portA(1, 1, 1, 2, 4'h9, "R6 R7 reset with write");
    portA(1, 0, 0, 2, '0, "R7 word written under reset");
    portB(1, 0, 1, 1, '0, "R6 port B reset beats read");
    portB(1, 0, 0, 0, '0, "R7 R2 port B sees write under reset");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 2);
    testResetState();
    testPowerUpZero();
    testNarrowToWide();
    testWideToNarrow();
    testEnableLow();
    testResetPriority();
    repeat (3) @(posedge clkA);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule